// File: doc/BRIEF.md
# Page-Mode Burst DRAM Controller

This block turns word-sized requests into strobe sequences for a DRAM cell array whose address pins are shared between a row half and a column half. A request word address is split: the upper bits name a row, the lower bits name a column. Opening a row puts the row half on the shared address pins while the row strobe falls. The column half then goes out with the column strobe. The controller leaves the row open after each access. A later request to the same row only runs a column cycle and skips both activation and precharge. A request to another row first releases the row strobe for a precharge interval.

A read carries a burst length. The controller reads the start column, then one word per clock from the next columns, wrapping inside the row. A refresh timer raises a busy flag at a fixed period. When the current transaction ends, the controller closes any open row, runs a refresh cycle with both strobes low, and drops the flag.

Requests enter on a valid/ready channel. `req_ready` is high only when the controller is idle and no refresh is pending. A request must hold `req_valid` and its fields steady until it is accepted. Read words leave on a valid/ready channel. While `rd_ready` is low, `rd_valid` and `rd_data` hold, and the burst pauses with the column strobe kept low.

Top module: `dramc_page_burst`

## Requirements
- R1: After reset, `req_ready` is 1, `rd_valid` is 0, `refresh_busy` is 0, and `dram_ras_n` and `dram_cas_n` are both 1 (no row open).
- R2: A word address is split as row = `req_addr[ROW_BITS+COL_BITS-1:COL_BITS]` and column = `req_addr[COL_BITS-1:0]`. A read returns the word last written to the same row and column.
- R3: When no row is open, the first read word appears on `rd_valid` exactly ROW_CYC clock edges after the accepting edge.
- R4: A read to the open row delivers its first word COL_CYC edges after acceptance. `dram_ras_n` stays 0 the whole time.
- R5: A read to a row other than the open one first holds `dram_ras_n` high for PRE_CYC cycles. Its first word appears PRE_CYC+ROW_CYC edges after acceptance.
- R6: A read with `req_len`=n returns n+1 words from consecutive columns. When `rd_ready` is high, the words come on consecutive clocks.
- R7: The burst column wraps from 2^COL_BITS-1 to 0 and stays in the same row.
- R8: A write stores `req_wdata` at exactly one word. `req_len` is ignored and no read word is produced.
- R9: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` and `rd_data` hold. No word is lost or repeated.
- R10: `refresh_busy` rises every REF_INTERVAL cycles. It stays high for at least REF_CYC cycles and falls when the refresh ends.
- R11: While `refresh_busy` is 1, `req_ready` is 0. A refresh closes the open row, so the next read pays the ROW_CYC latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = single-word write, 0 = burst read |
| req_addr | input | ROW_BITS+COL_BITS | Word address, row in the upper bits |
| req_len | input | LEN_BITS | Read burst length minus one |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read word present |
| rd_ready | input | 1 | Consumer takes the read word |
| rd_data | output | DATA_W | Read word |
| refresh_busy | output | 1 | Refresh pending or running |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_addr | output | max(ROW_BITS,COL_BITS) | Shared row/column address |

## Verification
The bench uses a 16-row by 8-column array of 16-bit words. It keeps ROW_CYC=25 and COL_CYC=8, sets PRE_CYC=3, and shortens the refresh to REF_CYC=6 every REF_INTERVAL=500 cycles. With only 8 columns, bursts of up to 8 words wrap around the row. With the short refresh period, several refreshes fall between ordinary traffic in one short run, so the latency after a refresh and the refresh period can both be measured. It covers closed-row, same-row and other-row latencies, and it runs a burst under a repeating consumer stall.

// File: rtl/dramc_pkg.sv
package dramc_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_ACT,
    S_COL,
    S_BURST,
    S_REF
  } dramc_state_e;
endpackage

// File: rtl/dramc_ref_timer.sv
module dramc_ref_timer #(
  parameter int INTERVAL = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  output logic due
);
  localparam int CW = $clog2(INTERVAL);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick <= '0;
      due  <= 1'b0;
    end else begin
      if (tick == LAST) begin
        tick <= '0;
        due  <= 1'b1;
      end else begin
        tick <= tick + 1'b1;
        if (done) due <= 1'b0;
      end
    end
  end

  AST_DUE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (due && !done) |=> due); // R10
endmodule

// File: rtl/dramc_col_ctr.sv
module dramc_col_ctr #(
  parameter int COL_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [COL_BITS-1:0] start,
  input  logic                step,
  output logic [COL_BITS-1:0] col
);
  always_ff @(posedge clk) begin
    if (!rst_n)    col <= '0;
    else if (load) col <= start;
    else if (step) col <= col + 1'b1;
  end

  AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && col == {COL_BITS{1'b1}}) |=> (col == '0)); // R7
endmodule

// File: rtl/dramc_cell_array.sv
module dramc_cell_array #(
  parameter int ROW_BITS = 6,
  parameter int COL_BITS = 4,
  parameter int DATA_W   = 16,
  parameter int AW       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 2 ** (ROW_BITS + COL_BITS);

  logic [DATA_W-1:0]   cells [DEPTH];
  logic [ROW_BITS-1:0] row_l;
  logic                ras_q;
  logic [COL_BITS-1:0] caddr;

  assign caddr = COL_BITS'(addr);
  assign rdata = cells[{row_l, caddr}];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q <= 1'b1;
      row_l <= '0;
    end else begin
      ras_q <= ras_n;
      // row strobe falling with column strobe high opens a row
      if (ras_q && !ras_n && cas_n) row_l <= ROW_BITS'(addr);
    end
  end

  always_ff @(posedge clk) begin
    if (!ras_n && !cas_n && !we_n) cells[{row_l, caddr}] <= wdata;
  end
endmodule

// File: rtl/dramc_page_burst.sv
module dramc_page_burst
  import dramc_pkg::*;
#(
  parameter int ROW_BITS     = 6,
  parameter int COL_BITS     = 4,
  parameter int DATA_W       = 16,
  parameter int LEN_BITS     = 3,
  parameter int ROW_CYC      = 25,
  parameter int COL_CYC      = 8,
  parameter int PRE_CYC      = 3,
  parameter int REF_CYC      = 24,
  parameter int REF_INTERVAL = 2000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [ROW_BITS+COL_BITS-1:0] req_addr,
  input  logic [LEN_BITS-1:0]          req_len,
  input  logic [DATA_W-1:0]            req_wdata,
  output logic                         rd_valid,
  input  logic                         rd_ready,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         refresh_busy,
  output logic                         dram_ras_n,
  output logic                         dram_cas_n,
  output logic                         dram_we_n,
  output logic [((ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS)-1:0] dram_addr
);
  localparam int WA   = ROW_BITS + COL_BITS;
  localparam int AW   = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS;
  localparam int TMAX = ROW_CYC + REF_CYC + PRE_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] T_ACT = TW'(ROW_CYC - COL_CYC - 1);
  localparam logic [TW-1:0] T_COL = TW'(COL_CYC - 1);
  localparam logic [TW-1:0] T_PRE = TW'(PRE_CYC - 1);
  localparam logic [TW-1:0] T_REF = TW'(REF_CYC - 1);

  dramc_state_e        state;
  logic [TW-1:0]       cnt;
  logic                open_q, go_ref, wr_q;
  logic [ROW_BITS-1:0] row_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [LEN_BITS-1:0] left;
  logic [COL_BITS-1:0] col;
  logic [DATA_W-1:0]   arr_rdata;
  logic                due, ref_done;
  logic [ROW_BITS-1:0] req_row;
  logic [COL_BITS-1:0] req_col;
  logic                hit, out_free, xfer_col, capture, col_step, accept;

  assign req_row   = req_addr[WA-1:COL_BITS];
  assign req_col   = req_addr[COL_BITS-1:0];
  assign req_ready = (state == S_IDLE) && !due;
  assign accept    = req_valid && req_ready;
  assign hit       = open_q && (req_row == row_q);
  assign out_free  = !rd_valid || rd_ready;
  assign xfer_col  = (state == S_COL) && (cnt == '0);
  assign capture   = ((xfer_col && !wr_q) || (state == S_BURST)) && out_free;
  assign col_step  = capture && (left != '0);
  assign ref_done  = (state == S_REF) && (cnt == '0);
  assign refresh_busy = due;

  assign dram_ras_n = !((state == S_ACT) || (state == S_COL) || (state == S_BURST) ||
                        (state == S_REF) || ((state == S_IDLE) && open_q));
  assign dram_cas_n = !((state == S_COL) || (state == S_BURST) || (state == S_REF));
  assign dram_we_n  = !(xfer_col && wr_q);
  assign dram_addr  = (state == S_ACT) ? AW'(row_q) : AW'(col);

  dramc_ref_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .done(ref_done), .due(due)
  );

  dramc_col_ctr #(.COL_BITS(COL_BITS)) u_col (
    .clk(clk), .rst_n(rst_n), .load(accept), .start(req_col),
    .step(col_step), .col(col)
  );

  dramc_cell_array #(
    .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W), .AW(AW)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
    .we_n(dram_we_n), .addr(dram_addr), .wdata(wdata_q), .rdata(arr_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      open_q  <= 1'b0;
      go_ref  <= 1'b0;
      wr_q    <= 1'b0;
      row_q   <= '0;
      wdata_q <= '0;
      left    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (capture) begin
        rd_valid <= 1'b1;
        rd_data  <= arr_rdata;
      end else if (rd_ready) begin
        rd_valid <= 1'b0;
      end

      unique case (state)
        S_IDLE: begin
          if (due) begin
            // refresh wins at a transaction boundary
            go_ref <= 1'b1;
            if (open_q) begin
              state  <= S_PRE;
              cnt    <= T_PRE;
              open_q <= 1'b0;
            end else begin
              state <= S_REF;
              cnt   <= T_REF;
            end
          end else if (req_valid) begin
            row_q   <= req_row;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            left    <= req_len;
            go_ref  <= 1'b0;
            if (hit) begin
              state <= S_COL;
              cnt   <= T_COL;
            end else if (open_q) begin
              state  <= S_PRE;
              cnt    <= T_PRE;
              open_q <= 1'b0;
            end else begin
              state <= S_ACT;
              cnt   <= T_ACT;
            end
          end
        end
        S_PRE: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (go_ref) begin
            state <= S_REF;
            cnt   <= T_REF;
          end else begin
            state <= S_ACT;
            cnt   <= T_ACT;
          end
        end
        S_ACT: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            state  <= S_COL;
            cnt    <= T_COL;
            open_q <= 1'b1;
          end
        end
        S_COL: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (wr_q) state <= S_IDLE;
          else if (capture) begin
            if (left == '0) state <= S_IDLE;
            else begin
              left  <= left - 1'b1;
              state <= S_BURST;
            end
          end
        end
        S_BURST: begin
          if (capture) begin
            if (left == '0) state <= S_IDLE;
            else left <= left - 1'b1;
          end
        end
        S_REF: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_busy |-> !req_ready); // R11
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R9
  AST_PRE_ROW_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PRE) |-> (dram_ras_n && dram_cas_n)); // R5
  AST_HIT_KEEPS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> (!dram_ras_n && !dram_cas_n)); // R4
endmodule

// File: tb/dramc_page_burst_tb.sv
module dramc_page_burst_tb;
  localparam int RB = 4, CB = 3, DW = 16, LB = 3;
  localparam int RC = 25, CC = 8, PC = 3, FC = 6, FI = 500;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rd_ready;
  logic [RB+CB-1:0] req_addr = '0;
  logic [LB-1:0] req_len = '0;
  logic [DW-1:0] req_wdata = '0, rd_data;
  logic req_ready, rd_valid, refresh_busy, dram_ras_n, dram_cas_n, dram_we_n;
  logic [RB-1:0] dram_addr;

  dramc_page_burst #(
    .ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW), .LEN_BITS(LB), .ROW_CYC(RC),
    .COL_CYC(CC), .PRE_CYC(PC), .REF_CYC(FC), .REF_INTERVAL(FI)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .refresh_busy(refresh_busy), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_addr(dram_addr)
  );

  always #2 clk = ~clk; // 4 ns period

  typedef struct { logic [DW-1:0] d; int t; string lq; string dq; } item_t;
  item_t exp_q[$];
  item_t mon_it;
  logic [DW-1:0] ref_mem [2**(RB+CB)];
  int cyc = 0, checks = 0, fails = 0, stalls = 0, rises = 0, last_rise = -1;
  int busy_len = 0;
  bit m_open = 0, lat_on = 1, stall_mode = 0, busy_prev = 0, ready_bad = 0, started = 0;
  logic [RB-1:0] m_row = '0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) rd_ready <= stall_mode ? ((cyc % 3) != 0) : 1'b1;

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic do_req(input bit wr, input logic [RB-1:0] row, input logic [CB-1:0] col,
                        input int len, input logic [DW-1:0] wd, input string dtag);
    int lat;
    string lrq;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = {row, col};
    req_len = LB'(len); req_wdata = wd;
    while (!req_ready) @(negedge clk);
    if (m_open && m_row == row) begin lat = CC; lrq = "R4"; end
    else if (m_open) begin lat = PC + RC; lrq = "R5"; end
    else begin lat = RC; lrq = "R3"; end
    m_open = 1; m_row = row;
    if (wr) ref_mem[{row, col}] = wd;
    else begin
      for (int k = 0; k <= len; k++) begin
        item_t it;
        logic [CB-1:0] c;
        c = col + CB'(k);
        it.d  = ref_mem[{row, c}];
        it.t  = lat_on ? (cyc + 1 + lat + k) : -1;
        it.lq = (k == 0) ? lrq : "R6";
        it.dq = (dtag != "") ? dtag : ((k == 0) ? "R2" : ((c < col) ? "R7" : "R6"));
        exp_q.push_back(it);
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: scoreboard and refresh observation
  always @(negedge clk) begin
    if (rst_n && started) begin
      if (rd_valid && rd_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R8", "unexpected read word", longint'(rd_data), 0);
        else begin
          mon_it = exp_q.pop_front();
          check(rd_data == mon_it.d, mon_it.dq, "data", longint'(rd_data), longint'(mon_it.d));
          if (mon_it.t >= 0) check(cyc == mon_it.t, mon_it.lq, "word cycle", cyc, mon_it.t);
        end
      end
      if (rd_valid && !rd_ready) stalls++;
      if (refresh_busy) begin
        m_open = 0;
        busy_len++;
        if (req_ready) ready_bad = 1;
      end
      if (refresh_busy && !busy_prev) begin
        if (last_rise >= 0) check(cyc - last_rise == FI, "R10", "refresh period", cyc - last_rise, FI);
        last_rise = cyc;
        rises++;
      end
      if (!refresh_busy && busy_prev) begin
        check(busy_len >= FC, "R10", "busy length", busy_len, FC);
        check(!ready_bad, "R11", "ready while busy", ready_bad, 0);
        busy_len = 0;
        ready_bad = 0;
      end
      busy_prev = refresh_busy;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    bit ras_bad;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    check(rd_valid == 1'b0, "R1", "rd_valid", rd_valid, 0);
    check(dram_ras_n && dram_cas_n, "R1", "strobes", {dram_ras_n, dram_cas_n}, 3);
    check(refresh_busy == 1'b0, "R1", "refresh_busy", refresh_busy, 0);
    started = 1;

    // fill rows 1, 2, 3, 5; the length field must be ignored on writes
    foreach (ref_mem[i]) ref_mem[i] = '0;
    for (int r = 0; r < 16; r++) begin
      if (r == 1 || r == 2 || r == 3 || r == 5)
        for (int c = 0; c < 8; c++)
          do_req(1'b1, RB'(r), CB'(c), c, DW'(16'h1000 + r * 256 + c * 17), "");
    end
    do_req(1'b1, 4'd3, 3'd2, 5, 16'hBEEF, "");          // R8: len=5 on a write
    do_req(1'b0, 4'd3, 3'd0, 7, '0, "R8");              // neighbours unchanged
    drain();

    do_req(1'b0, 4'd1, 3'd0, 0, '0, "");                 // row change, R5
    drain();
    do_req(1'b0, 4'd1, 3'd3, 3, '0, "");                 // same row, R4
    ras_bad = 0;
    repeat (CC + 3) begin @(negedge clk); if (dram_ras_n) ras_bad = 1; end
    check(!ras_bad, "R4", "row strobe released on hit", ras_bad, 0);
    drain();
    do_req(1'b0, 4'd1, 3'd6, 4, '0, "");                 // wrap, R7
    drain();
    do_req(1'b0, 4'd2, 3'd0, 7, '0, "");                 // full row, R6
    drain();

    // consumer back-pressure, R9
    lat_on = 0; stall_mode = 1;
    do_req(1'b0, 4'd5, 3'd1, 7, '0, "R9");
    drain();
    stall_mode = 0;
    @(negedge clk); @(negedge clk);
    lat_on = 1;
    check(stalls > 0, "R9", "stall cycles seen", stalls, 1);

    // after a refresh the row is closed, R11 / R3
    while (!refresh_busy) @(negedge clk);
    while (refresh_busy) @(negedge clk);
    do_req(1'b0, 4'd2, 3'd4, 1, '0, "");
    drain();

    // mixed traffic across refreshes
    for (int i = 0; i < 40; i++)
      do_req(1'b0, (i % 3 == 0) ? 4'd5 : 4'd1, CB'(i), i % 4, '0, "");
    drain();
    while (rises < 3) @(negedge clk);
    while (refresh_busy) @(negedge clk);
    check(rises >= 3, "R10", "refresh count", rises, 3);
    check(exp_q.size() == 0, "R6", "words outstanding", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule